// File: doc/BRIEF.md
# Host-Settable Elapsed Timestamp

This block gives a device a 64-bit nanosecond timestamp that the host can set. It has no time-of-day clock of its own. A free-running local counter advances by a fixed number of nanoseconds on every clock. When the host loads an absolute time, the block stores two values: that time, and the local counter value at the moment of the load. From then on, a read returns the stored host time plus the local time that has passed since the load.

Until the host has loaded a time at least once, every read returns zero. A later load replaces the earlier anchor completely. All arithmetic is unsigned and modulo 2^64. The block sits behind whatever command path carries the host's set and get requests. That path pulses `set_i` together with the host time, pulses `rd_i` to sample, and takes the result from `ts_o` one clock later.

Top module: `host_timestamp`

## Requirements
- R1: After synchronous reset, `ts_o` is 0. A read issued before any set returns 0.
- R2: The local counter starts at 0 at reset and advances by `NS_PER_CLK` on every clock. It wraps modulo 2^64, so elapsed time that crosses the wrap point is still correct.
- R3: A set captures `host_time_i` and the current local counter value, and marks the timestamp valid. A read in the clock right after the set returns the host time plus `NS_PER_CLK`.
- R4: Once the timestamp is valid, a read presents host time + (local now − local at set), modulo 2^64, on `ts_o` in the clock after `rd_i`. Two reads in back-to-back clocks differ by exactly `NS_PER_CLK`.
- R5: A new set overrides the earlier one. A read in the same clock as a set returns the value from the earlier anchor, or 0 if there was none. Reads from the next clock onward use the new anchor.
- R6: The valid mark is cleared only by reset, never by a read or by elapsed time. The final sum wraps modulo 2^64.
- R7: `ts_o` holds its last value on every clock without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | 1 | One-clock strobe that loads the host time |
| host_time_i | input | 64 | Absolute host time in ns, sampled with `set_i` |
| rd_i | input | 1 | One-clock strobe that samples the timestamp |
| ts_o | output | 64 | Timestamp result, updated one clock after `rd_i` |

## Verification
Reads are tried in several situations: before any set, right after a set, after idle gaps, in back-to-back clocks, in the same clock as a new set, and after a mid-run reset. Each situation separates a different fault. A wrong offset shows up right after a set, a wrong step rate shows up on back-to-back reads, wrong same-cycle ordering shows up when read and set coincide, and a valid mark that survives reset shows up after the mid-run reset. A host time just below 2^64 checks that the final sum wraps. A second instance whose step is a quarter of 2^64 wraps its local counter every four clocks, which checks the modular subtraction.

// File: rtl/ts_pkg.sv
package ts_pkg;

    localparam int TS_W = 64;

    typedef logic [TS_W-1:0] ns_t;

    // Anchor recorded by a host set
    typedef struct packed {
        logic valid;
        ns_t  base;   // host time at the set
        ns_t  mark;   // local time at the set
    } anchor_t;

    function automatic ns_t ts_elapsed(ns_t now, ns_t mark);
        return now - mark;
    endfunction

    function automatic ns_t ts_compose(anchor_t a, ns_t now);
        if (a.valid) begin
            return a.base + ts_elapsed(now, a.mark);
        end
        return '0;
    endfunction

endpackage

// File: rtl/ts_local_clock.sv
module ts_local_clock
    import ts_pkg::*;
#(
    parameter ns_t NS_PER_CLK = 64'd1
) (
    input  logic clk,
    input  logic rst,
    output ns_t  now_o
);

    ns_t count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + NS_PER_CLK;
        end
    end

    assign now_o = count_q;

endmodule

// File: rtl/ts_anchor.sv
module ts_anchor
    import ts_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    set_i,
    input  ns_t     host_i,
    input  ns_t     now_i,
    output anchor_t anchor_o
);

    anchor_t anc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            anc_q <= '0;
        end else if (set_i) begin
            anc_q.valid <= 1'b1;
            anc_q.base  <= host_i;
            anc_q.mark  <= now_i;
        end
    end

    assign anchor_o = anc_q;

endmodule

// File: rtl/ts_readout.sv
module ts_readout
    import ts_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_i,
    input  anchor_t anchor_i,
    input  ns_t     now_i,
    output ns_t     ts_o
);

    ns_t value_d;
    ns_t out_q;

    always_comb begin
        value_d = ts_compose(anchor_i, now_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (rd_i) begin
            out_q <= value_d;
        end
    end

    assign ts_o = out_q;

endmodule

// File: rtl/host_timestamp.sv
module host_timestamp
    import ts_pkg::*;
#(
    parameter ns_t NS_PER_CLK = 64'd1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_i,
    input  logic [TS_W-1:0] host_time_i,
    input  logic            rd_i,
    output logic [TS_W-1:0] ts_o
);

    ns_t     now;
    anchor_t anchor;
    logic    ts_valid;

    ts_local_clock #(.NS_PER_CLK(NS_PER_CLK)) u_clock (
        .clk   (clk),
        .rst   (rst),
        .now_o (now)
    );

    ts_anchor u_anchor (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_i),
        .host_i   (host_time_i),
        .now_i    (now),
        .anchor_o (anchor)
    );

    ts_readout u_readout (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (rd_i),
        .anchor_i (anchor),
        .now_i    (now),
        .ts_o     (ts_o)
    );

    assign ts_valid = anchor.valid;

endmodule

// File: rtl/ts_checker.sv
module ts_checker
    import ts_pkg::*;
#(
    parameter ns_t NS_PER_CLK = 64'd1
) (
    input logic clk,
    input logic rst,
    input logic set_i,
    input ns_t  host_time_i,
    input logic rd_i,
    input ns_t  ts_o,
    input logic valid
);

    logic seen_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_set <= 1'b0;
        end else if (set_i) begin
            seen_set <= 1'b1;
        end
    end

    // R1: no set yet, so a read yields zero
    a_r1_zero_before_set: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !seen_set) |=> (ts_o == '0));

    // R3: a read right after a set yields host time plus one step
    a_r3_read_after_set: assert property (@(posedge clk) disable iff (rst)
        (set_i && !rd_i) ##1 (rd_i && !set_i) |=>
            (ts_o == $past(host_time_i, 2) + NS_PER_CLK));

    // R4: back-to-back reads differ by one step
    a_r4_step_between_reads: assert property (@(posedge clk) disable iff (rst)
        (seen_set && rd_i && !set_i) ##1 (rd_i && !set_i) |=>
            ((ts_o - $past(ts_o)) == NS_PER_CLK));

    // R6: valid never drops outside reset
    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        valid |=> valid);

    // R7: no read, output held
    a_r7_hold_without_read: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(ts_o));

endmodule

bind host_timestamp ts_checker #(.NS_PER_CLK(NS_PER_CLK)) u_ts_checker (
    .clk         (clk),
    .rst         (rst),
    .set_i       (set_i),
    .host_time_i (host_time_i),
    .rd_i        (rd_i),
    .ts_o        (ts_o),
    .valid       (ts_valid)
);

// File: tb/tb_host_timestamp.sv
module tb_host_timestamp;

    localparam logic [63:0] NS  = 64'd8;
    localparam logic [63:0] WNS = 64'h4000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic        set_i = 1'b0, rd_i = 1'b0;
    logic [63:0] host  = '0;
    logic [63:0] ts;

    logic        w_set = 1'b0, w_rd = 1'b0;
    logic [63:0] w_host = '0;
    logic [63:0] w_ts;

    host_timestamp #(.NS_PER_CLK(NS)) dut (
        .clk(clk), .rst(rst), .set_i(set_i), .host_time_i(host),
        .rd_i(rd_i), .ts_o(ts)
    );

    host_timestamp #(.NS_PER_CLK(WNS)) dut_wrap (
        .clk(clk), .rst(rst), .set_i(w_set), .host_time_i(w_host),
        .rd_i(w_rd), .ts_o(w_ts)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Expected-value model built from the requirements
    logic [63:0] m_tick = '0;
    logic [63:0] m_base = '0;
    logic [63:0] m_mark = '0;
    logic        m_valid = 1'b0;

    always @(posedge clk) begin
        if (rst) m_tick <= '0;
        else     m_tick <= m_tick + NS;
    end

    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_exp = '0;
    logic        rd_d = 1'b0;

    always @(posedge clk) rd_d <= rst ? 1'b0 : rd_i;

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops and compares results as they appear
    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_exp = e;
            check(ts, e, t);
        end
    end

    // Driver: called at a negedge, runs one clock
    task automatic step(input bit s, input logic [63:0] h, input bit r, input string tag);
        set_i = s; host = h; rd_i = r;
        if (r) begin
            exp_q.push_back(m_valid ? m_base + (m_tick - m_mark) : 64'd0);
            tag_q.push_back(tag);
        end
        if (s) begin
            m_base  = h;
            m_mark  = m_tick;
            m_valid = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        set_i = 1'b0; rd_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, "");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ts, 64'd0, "R1");           // R1 reset value
        rst = 1'b0;
        step(0, '0, 1, "R1");             // R1 read before set
        idle(3);
        step(0, '0, 1, "R1");

        step(1, 64'd1000, 0, "R3");       // R3 set
        step(0, '0, 1, "R3");             // R3 read right after
        idle(5);
        step(0, '0, 1, "R4");             // R4 after gap
        step(0, '0, 1, "R2");             // R2 back-to-back step
        step(0, '0, 1, "R4");

        idle(2);
        step(1, 64'h0000_1234_0000_0000, 1, "R5"); // R5 read sees old anchor
        step(0, '0, 1, "R5");             // R5 new anchor in effect

        step(1, 64'hFFFF_FFFF_FFFF_FFEC, 0, "R6");
        idle(4);
        step(0, '0, 1, "R6");             // R6 sum wraps
        idle(4);
        check(ts, last_exp, "R7");        // R7 hold
        idle(40);
        step(0, '0, 1, "R6");             // R6 valid persists
        idle(3);
        check(ts, last_exp, "R7");

        // R6 reset clears valid
        rst = 1'b1; m_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        check(ts, 64'd0, "R1");
        rst = 1'b0;
        idle(2);
        step(0, '0, 1, "R6");

        // R2 local counter wrap on second instance
        w_host = 64'd5; w_set = 1'b1;
        @(negedge clk);
        w_set = 1'b0;
        repeat (4) @(negedge clk);
        w_rd = 1'b1;
        @(negedge clk);
        w_rd = 1'b0;
        check(w_ts, 64'd5 + WNS, "R2");
        w_rd = 1'b1;
        @(negedge clk);
        w_rd = 1'b0;
        check(w_ts, 64'd5 + 64'h8000_0000_0000_0000, "R2");

        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule